// File: doc/BRIEF.md
# Dual-Load Bank Conflict Detector

This block sits ahead of a banked data cache that serves two loads per cycle. Each load port presents the two operands of its address: a base value and an offset. The cache is interleaved on low-order address bits. The block therefore adds only the few low bits of each operand pair that decide the bank, plus the word-offset bits below them. This yields each port's bank number long before a full-width address add could finish.

The two bank numbers are compared. When both ports are valid and name the same bank, the conflict flag rises. Port 0 holds the older load in program order, so it keeps its grant. Port 1 is denied and is replayed by the issue logic on the next cycle. Bank selection uses only untranslated low bits, so address translation has no bearing on the result. All outputs are registered one cycle after the inputs.

Top module: `bank_conflict_top`

## Requirements
- R1: Each port's bank output equals bits [OFS_W+BANK_W-1:OFS_W] of the full-width sum base+offset, where BANK_W = log2(NUM_BANKS); the defaults give bits [4:3] for 4 banks and 8-byte words.
- R2: A carry out of the word-offset bits [OFS_W-1:0] propagates into the bank field (for example 0x7 + 0x1 selects bank 1).
- R3: A carry out of the top bank bit is discarded, and operand bits above the bank field have no effect on the bank output (for example 0x18 + 0x08 selects bank 0).
- R4: The conflict output is 1 exactly when both valid inputs were 1 and both ports computed the same bank.
- R5: Port 0's grant equals port 0's valid input, whatever port 1 does.
- R6: Port 1's grant is 1 only when port 1 was valid and no conflict was flagged.
- R7: All outputs reflect the inputs present at the previous rising clock edge, and they hold steady between edges.
- R8: While rst_ni is low, both grants, the conflict flag and both bank outputs are 0.
- R9: A port whose valid input is 0 receives no grant and cannot cause a conflict, even when its bank matches the other port's bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| p0_valid_i | input | 1 | Port 0 load present |
| p0_base_i | input | ADDR_W | Port 0 base operand |
| p0_offs_i | input | ADDR_W | Port 0 offset operand |
| p1_valid_i | input | 1 | Port 1 load present |
| p1_base_i | input | ADDR_W | Port 1 base operand |
| p1_offs_i | input | ADDR_W | Port 1 offset operand |
| p0_bank_o | output | BANK_W | Port 0 bank number |
| p1_bank_o | output | BANK_W | Port 1 bank number |
| p0_grant_o | output | 1 | Port 0 may access its bank |
| p1_grant_o | output | 1 | Port 1 may access its bank |
| conflict_o | output | 1 | Both loads target one bank |

## Verification
A wrong carry treatment in the narrow adder shows up as a wrong bank number on the very next cycle, but only for operand pairs whose low bits carry across the word-offset boundary or out of the bank field. For that reason the low five bits of both operands are swept exhaustively, with random upper bits. A wrong comparison or priority is visible at the grant and conflict outputs one cycle after the pair is presented. Cycling the valid patterns during the sweep exposes any leak of an invalid port into the arbitration.

// File: rtl/bank_pkg.sv
package bank_pkg;
  localparam int unsigned DEF_ADDR_W    = 32;
  localparam int unsigned DEF_NUM_BANKS = 4;
  localparam int unsigned DEF_OFS_W     = 3;
  localparam int unsigned NUM_PORTS     = 2;
endpackage

// File: rtl/bank_sel_adder.sv
module bank_sel_adder #(
  parameter int unsigned OFS_W  = 3,
  parameter int unsigned BANK_W = 2,
  localparam int unsigned LOW_W = OFS_W + BANK_W
) (
  input  logic [LOW_W-1:0]  base_i,
  input  logic [LOW_W-1:0]  offs_i,
  output logic [BANK_W-1:0] bank_o
);
  logic [LOW_W-1:0] low_sum;
  // carry out of the top bank bit is dropped by the width
  assign low_sum = base_i + offs_i;
  assign bank_o  = low_sum[LOW_W-1:OFS_W];
endmodule

// File: rtl/bank_arbiter.sv
module bank_arbiter #(
  parameter int unsigned BANK_W = 2
) (
  input  logic              v0_i,
  input  logic              v1_i,
  input  logic [BANK_W-1:0] b0_i,
  input  logic [BANK_W-1:0] b1_i,
  output logic              g0_o,
  output logic              g1_o,
  output logic              conflict_o
);
  always_comb begin
    conflict_o = v0_i && v1_i && (b0_i == b1_i);
    g0_o       = v0_i;                 // older load always wins
    g1_o       = v1_i && !conflict_o;
  end
endmodule

// File: rtl/bank_conflict_top.sv
module bank_conflict_top
  import bank_pkg::*;
#(
  parameter int unsigned ADDR_W    = DEF_ADDR_W,
  parameter int unsigned NUM_BANKS = DEF_NUM_BANKS,
  parameter int unsigned OFS_W     = DEF_OFS_W,
  localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int unsigned LOW_W    = OFS_W + BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              p0_valid_i,
  input  logic [ADDR_W-1:0] p0_base_i,
  input  logic [ADDR_W-1:0] p0_offs_i,
  input  logic              p1_valid_i,
  input  logic [ADDR_W-1:0] p1_base_i,
  input  logic [ADDR_W-1:0] p1_offs_i,
  output logic [BANK_W-1:0] p0_bank_o,
  output logic [BANK_W-1:0] p1_bank_o,
  output logic              p0_grant_o,
  output logic              p1_grant_o,
  output logic              conflict_o
);
  logic [NUM_PORTS-1:0][LOW_W-1:0]  base_lo;
  logic [NUM_PORTS-1:0][LOW_W-1:0]  offs_lo;
  logic [NUM_PORTS-1:0][BANK_W-1:0] bank_d;
  logic g0_d, g1_d, conf_d;

  assign base_lo[0] = p0_base_i[LOW_W-1:0];
  assign offs_lo[0] = p0_offs_i[LOW_W-1:0];
  assign base_lo[1] = p1_base_i[LOW_W-1:0];
  assign offs_lo[1] = p1_offs_i[LOW_W-1:0];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    bank_sel_adder #(.OFS_W(OFS_W), .BANK_W(BANK_W)) u_add (
      .base_i (base_lo[p]),
      .offs_i (offs_lo[p]),
      .bank_o (bank_d[p])
    );
  end

  bank_arbiter #(.BANK_W(BANK_W)) u_arb (
    .v0_i       (p0_valid_i),
    .v1_i       (p1_valid_i),
    .b0_i       (bank_d[0]),
    .b1_i       (bank_d[1]),
    .g0_o       (g0_d),
    .g1_o       (g1_d),
    .conflict_o (conf_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p0_bank_o  <= '0;
      p1_bank_o  <= '0;
      p0_grant_o <= 1'b0;
      p1_grant_o <= 1'b0;
      conflict_o <= 1'b0;
    end else begin
      p0_bank_o  <= bank_d[0];
      p1_bank_o  <= bank_d[1];
      p0_grant_o <= g0_d;
      p1_grant_o <= g1_d;
      conflict_o <= conf_d;
    end
  end
endmodule

// File: rtl/bank_conflict_chk.sv
module bank_conflict_chk #(
  parameter int unsigned BANK_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              p0_valid_i,
  input logic              p1_valid_i,
  input logic [BANK_W-1:0] p0_bank_o,
  input logic [BANK_W-1:0] p1_bank_o,
  input logic              p0_grant_o,
  input logic              p1_grant_o,
  input logic              conflict_o
);
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  assert_conflict_prio_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict_o |-> (p0_grant_o && !p1_grant_o));

  assert_p0_grant_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |=> (p0_grant_o == $past(p0_valid_i)));

  assert_invalid_no_conf_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !(p0_valid_i && p1_valid_i)) |=> !conflict_o);

  assert_same_bank_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && p0_valid_i && p1_valid_i) |=> (conflict_o == (p0_bank_o == p1_bank_o)));

  assert_p1_needs_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !p1_valid_i) |=> !p1_grant_o);
endmodule

bind bank_conflict_top bank_conflict_chk #(.BANK_W(BANK_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .p0_valid_i (p0_valid_i),
  .p1_valid_i (p1_valid_i),
  .p0_bank_o  (p0_bank_o),
  .p1_bank_o  (p1_bank_o),
  .p0_grant_o (p0_grant_o),
  .p1_grant_o (p1_grant_o),
  .conflict_o (conflict_o)
);

// File: tb/sim_bank_conflict_top.sv
module sim_bank_conflict_top;
  localparam int AW = 32;
  localparam int OW = 3;
  localparam int BW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic v0 = 1'b0, v1 = 1'b0;
  logic [AW-1:0] b0 = '0, o0 = '0, b1 = '0, o1 = '0;
  logic [BW-1:0] bank0, bank1;
  logic g0, g1, conf;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  bank_conflict_top u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .p0_valid_i(v0), .p0_base_i(b0), .p0_offs_i(o0),
    .p1_valid_i(v1), .p1_base_i(b1), .p1_offs_i(o1),
    .p0_bank_o(bank0), .p1_bank_o(bank1),
    .p0_grant_o(g0), .p1_grant_o(g1), .conflict_o(conf)
  );

  function automatic logic [BW-1:0] ref_bank(input logic [AW-1:0] a, input logic [AW-1:0] b);
    logic [AW-1:0] s;
    s = a + b;
    return s[OW+BW-1:OW];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // apply current inputs, wait one edge, check registered outputs
  task automatic step_check(input string req);
    logic [BW-1:0] e0, e1;
    logic ec;
    e0 = ref_bank(b0, o0);
    e1 = ref_bank(b1, o1);
    ec = v0 && v1 && (e0 == e1);
    @(posedge clk); #2;
    chk({req, " bank0"}, int'(bank0), int'(e0));
    chk({req, " bank1"}, int'(bank1), int'(e1));
    chk("R4 conflict", int'(conf), int'(ec));
    chk("R5 grant0", int'(g0), int'(v0));
    chk("R6 grant1", int'(g1), int'(v1 && !ec));
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R8 reset state
    v0 = 1'b1; v1 = 1'b1; b0 = 32'h8; b1 = 32'h8;
    repeat (3) @(posedge clk);
    #2;
    chk("R8 reset grant0", int'(g0), 0);
    chk("R8 reset grant1", int'(g1), 0);
    chk("R8 reset conflict", int'(conf), 0);
    chk("R8 reset bank0", int'(bank0), 0);
    chk("R8 reset bank1", int'(bank1), 0);
    rst_n = 1'b1;

    // R2 carry from word offset into bank
    v0 = 1; v1 = 0; b0 = 32'h7; o0 = 32'h1; b1 = 32'h0; o1 = 32'h0;
    step_check("R2");
    chk("R2 carry bank", int'(bank0), 1);

    // R3 wrap of bank field and high bits ignored
    b0 = 32'h18; o0 = 32'h08; b1 = 32'hFFFF_FFF8; o1 = 32'h0000_0008; v1 = 1;
    step_check("R3");
    chk("R3 wrap bank0", int'(bank0), 0);
    chk("R3 wrap bank1", int'(bank1), 0);
    b0 = 32'hABCD_0008; o0 = 32'h1234_0000;
    step_check("R3");
    chk("R3 high bits bank0", int'(bank0), 1);

    // R9 invalid port with matching bank
    v0 = 1; v1 = 0; b0 = 32'h10; o0 = 0; b1 = 32'h10; o1 = 0;
    step_check("R9");
    chk("R9 no conflict", int'(conf), 0);
    chk("R9 no grant1", int'(g1), 0);
    v0 = 0; v1 = 1;
    step_check("R9");
    chk("R9 no grant0", int'(g0), 0);
    chk("R9 grant1 alone", int'(g1), 1);

    // R7 outputs hold between edges, then follow
    v0 = 1; v1 = 1; b0 = 32'h08; o0 = 0; b1 = 32'h08; o1 = 0;
    step_check("R7");
    v1 = 0; b0 = 32'h18;
    #3;
    chk("R7 hold conflict", int'(conf), 1);
    chk("R7 hold bank0", int'(bank0), 1);
    step_check("R7");
    chk("R7 updated bank0", int'(bank0), 3);

    // R1 sweep of low five bits of both operands, upper bits random
    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 32; b++) begin
        b0 = {$urandom() % 32'h0800_0000, a[4:0]};
        o0 = {$urandom() % 32'h0800_0000, b[4:0]};
        b1 = {$urandom() % 32'h0800_0000, b[4:0]};
        o1 = {$urandom() % 32'h0800_0000, 5'((a * 3 + 5) % 32)};
        v0 = ((a + b) % 4) != 1;
        v1 = ((a + b) % 4) != 2;
        step_check("R1");
      end
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule